// File: doc/BRIEF.md
# Prioritized External Interrupt Controller

This block gathers three external interrupt sources of a small microcontroller and turns them into one request toward the CPU, or toward a data transfer engine, with the priority and routing set in three byte-wide registers. The sources are a non-maskable line whose active edge can be chosen, an active-low level line that a watchdog overflow can also drive, and an active-low line whose falling edge is caught and held until it is served.

All pins pass through a two-flop synchronizer. Edges are found by comparing the synchronized level with its value one cycle earlier. Each maskable source has a 3-bit priority. A source reaches the CPU only when its priority is strictly above the CPU's current mask level. The non-maskable source always reaches the CPU and always wins. When the CPU accepts a source, it pulses `cpu_ack` with the source code on `ack_src`. One cycle later the controller presents the mask level the CPU must load. For a maskable source it also presents a request to clear the trace bit. A source routed to the transfer engine raises `dtc_req` and never `cpu_req`.

Source codes, used on `cpu_src`, `dtc_src` and `ack_src`: 0 = non-maskable, 1 = level source, 2 = edge source, 3 = none. Register addresses: 0 = control, 1 = priority, 2 = routing. Address 3 and all unused bits read as 0.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset all register fields are 0, `reg_rdata` reads 0 at every address, and `cpu_req`, `dtc_req`, `mask_load` and `tr_clr` are 0.
- R2: The register layout is: control (address 0) bit0 = non-maskable rising-edge select, bit1 = level source enable, bit2 = edge source enable; priority (address 1) bits[2:0] = level source priority, bits[6:4] = edge source priority; routing (address 2) bit0 = level source to transfer engine, bit1 = edge source to transfer engine. Written bits read back, and every other bit reads 0.
- R3: With control bit0 at 0, a falling edge on `nmi_pin` latches a non-maskable request. With bit0 at 1, a rising edge latches it. The opposite edge has no effect. The request is presented as source 0 whatever the mask level is.
- R4: While the level source is enabled, a low `lvl_pin_n` requests source 1. Once the pin returns high the request disappears, with nothing held.
- R5: `wdt_ovf` requests source 1 only while `wdt_en` is 1 and `wdt_itv_mode` is 0, independent of the level source enable.
- R6: While the edge source is enabled, a falling edge on `edg_pin_n` latches a request for source 2. The request stays after the pin goes high. A rising edge, or any edge while the source is disabled, has no effect.
- R7: A maskable source reaches `cpu_req` only when its priority is strictly greater than `cpu_mask`.
- R8: Among the requests pending for the CPU, source 0 wins. Otherwise the higher priority wins. On equal priority, source 1 wins over source 2.
- R9: One cycle after an accept, `mask_load` pulses with `new_mask` equal to the accepted source's priority, or 7 for source 0. `tr_clr` pulses with it for sources 1 and 2 only. An accept of source 2 or 0 clears that source's latched request.
- R10: A new edge on the edge source after its accept is latched. It is held off while the mask is not below its priority, and it is presented once the mask drops.
- R11: A source whose routing bit is set raises `dtc_req` with its code on `dtc_src`, ignores the CPU mask, never raises `cpu_req`, and uses the R8 order among routed sources. A `dtc_ack` while `dtc_src` is 2 clears the edge latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Non-maskable interrupt pin |
| lvl_pin_n | input | 1 | Active-low level request pin |
| edg_pin_n | input | 1 | Falling-edge request pin |
| wdt_ovf | input | 1 | Watchdog overflow flag |
| wdt_en | input | 1 | Watchdog running |
| wdt_itv_mode | input | 1 | Watchdog in interval-timer mode |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| cpu_mask | input | 3 | Current CPU interrupt mask level |
| cpu_req | output | 1 | Interrupt request to CPU |
| cpu_src | output | 2 | Source code of the CPU request |
| cpu_ack | input | 1 | CPU accept pulse |
| ack_src | input | 2 | Source code being accepted |
| mask_load | output | 1 | New mask level valid |
| new_mask | output | 3 | Mask level the CPU must load |
| tr_clr | output | 1 | CPU must clear its trace bit |
| dtc_req | output | 1 | Request to the transfer engine |
| dtc_src | output | 2 | Source code of the transfer request |
| dtc_ack | input | 1 | Transfer engine accept pulse |

## Verification
Each source is tried with both pin directions, so a wrong edge sense or a level mistaken for a latch shows up: the level source drops when its pin rises, while the edge source stays held. Priority pairs are tried above, equal to and below the mask, and in both orders, which separates strict from non-strict comparison and exposes a wrong tie-break. The accept sequence is followed by a second edge under a raised mask and then a lowered mask. This shows that the latch, the mask compare and the clearing on accept work together. The routing settings are swapped to show that a routed source leaves the CPU side untouched.

// File: rtl/eic_pkg.sv
package eic_pkg;
    localparam int PRI_W  = 3;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int SRC_W  = 2;

    localparam logic [SRC_W-1:0] SRC_NMI  = 2'd0;
    localparam logic [SRC_W-1:0] SRC_LVL  = 2'd1;
    localparam logic [SRC_W-1:0] SRC_EDG  = 2'd2;
    localparam logic [SRC_W-1:0] SRC_NONE = 2'd3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_PRIO  = 2'd1;
    localparam logic [ADDR_W-1:0] A_ROUTE = 2'd2;

    typedef struct packed {
        logic             nmi_rise;
        logic             lvl_en;
        logic             edg_en;
        logic [PRI_W-1:0] lvl_pri;
        logic [PRI_W-1:0] edg_pri;
        logic             lvl_dtc;
        logic             edg_dtc;
    } cfg_t;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int             N       = 3,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: RST_VAL, s2: RST_VAL, prev: RST_VAL};
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign level[i] = st_q.s2[i];
        assign rise[i]  = st_q.s2[i] & ~st_q.prev[i];
        assign fall[i]  = ~st_q.s2[i] & st_q.prev[i];
    end
endmodule

// File: rtl/eic_regs.sv
module eic_regs
    import eic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output cfg_t              cfg
);
    localparam int EDG_LSB = 4;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            unique case (addr)
                A_CTRL: begin
                    cfg_d.nmi_rise = wdata[0];
                    cfg_d.lvl_en   = wdata[1];
                    cfg_d.edg_en   = wdata[2];
                end
                A_PRIO: begin
                    cfg_d.lvl_pri = wdata[PRI_W-1:0];
                    cfg_d.edg_pri = wdata[EDG_LSB +: PRI_W];
                end
                A_ROUTE: begin
                    cfg_d.lvl_dtc = wdata[0];
                    cfg_d.edg_dtc = wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL: begin
                rdata[0] = cfg_q.nmi_rise;
                rdata[1] = cfg_q.lvl_en;
                rdata[2] = cfg_q.edg_en;
            end
            A_PRIO: begin
                rdata[PRI_W-1:0]         = cfg_q.lvl_pri;
                rdata[EDG_LSB +: PRI_W]  = cfg_q.edg_pri;
            end
            A_ROUTE: begin
                rdata[0] = cfg_q.lvl_dtc;
                rdata[1] = cfg_q.edg_dtc;
            end
            default: rdata = '0;
        endcase
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/eic_pick.sv
module eic_pick
    import eic_pkg::*;
(
    input  logic             v_nmi,
    input  logic             v_lvl,
    input  logic [PRI_W-1:0] lvl_pri,
    input  logic             v_edg,
    input  logic [PRI_W-1:0] edg_pri,
    output logic             req,
    output logic [SRC_W-1:0] src
);
    always_comb begin
        if (v_nmi)                src = SRC_NMI;
        else if (v_lvl && v_edg)  src = (edg_pri > lvl_pri) ? SRC_EDG : SRC_LVL;
        else if (v_lvl)           src = SRC_LVL;
        else if (v_edg)           src = SRC_EDG;
        else                      src = SRC_NONE;
        req = v_nmi | v_lvl | v_edg;
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_pin,
    input  logic              lvl_pin_n,
    input  logic              edg_pin_n,
    input  logic              wdt_ovf,
    input  logic              wdt_en,
    input  logic              wdt_itv_mode,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [PRI_W-1:0]  cpu_mask,
    output logic              cpu_req,
    output logic [SRC_W-1:0]  cpu_src,
    input  logic              cpu_ack,
    input  logic [SRC_W-1:0]  ack_src,
    output logic              mask_load,
    output logic [PRI_W-1:0]  new_mask,
    output logic              tr_clr,
    output logic              dtc_req,
    output logic [SRC_W-1:0]  dtc_src,
    input  logic              dtc_ack
);
    localparam int NPIN = 3;
    localparam int P_NMI = 0;
    localparam int P_LVL = 1;
    localparam int P_EDG = 2;
    localparam logic [NPIN-1:0] PIN_IDLE = 3'b110;

    typedef struct packed {
        logic             nmi_pend;
        logic             edg_pend;
        logic             mask_load;
        logic [PRI_W-1:0] new_mask;
        logic             tr_clr;
    } st_t;

    st_t  st_d, st_q;
    cfg_t cfg;

    logic [NPIN-1:0] pin_lvl, pin_rise, pin_fall;
    logic nmi_edge, lvl_act, edg_set, nmi_clr, edg_clr;
    logic cpu_v_lvl, cpu_v_edg, dtc_v_lvl, dtc_v_edg;

    eic_regs regs_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    eic_sync #(.N(NPIN), .RST_VAL(PIN_IDLE)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   ({edg_pin_n, lvl_pin_n, nmi_pin}),
        .level (pin_lvl),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    always_comb begin
        nmi_edge = cfg.nmi_rise ? pin_rise[P_NMI] : pin_fall[P_NMI];
        lvl_act  = (cfg.lvl_en & ~pin_lvl[P_LVL])
                 | (wdt_ovf & wdt_en & ~wdt_itv_mode);
        edg_set  = cfg.edg_en & pin_fall[P_EDG];

        cpu_v_lvl = lvl_act & ~cfg.lvl_dtc & (cfg.lvl_pri > cpu_mask);
        cpu_v_edg = st_q.edg_pend & ~cfg.edg_dtc & (cfg.edg_pri > cpu_mask);
        dtc_v_lvl = lvl_act & cfg.lvl_dtc;
        dtc_v_edg = st_q.edg_pend & cfg.edg_dtc;
    end

    eic_pick cpu_pick_i (
        .v_nmi   (st_q.nmi_pend),
        .v_lvl   (cpu_v_lvl),
        .lvl_pri (cfg.lvl_pri),
        .v_edg   (cpu_v_edg),
        .edg_pri (cfg.edg_pri),
        .req     (cpu_req),
        .src     (cpu_src)
    );

    eic_pick dtc_pick_i (
        .v_nmi   (1'b0),
        .v_lvl   (dtc_v_lvl),
        .lvl_pri (cfg.lvl_pri),
        .v_edg   (dtc_v_edg),
        .edg_pri (cfg.edg_pri),
        .req     (dtc_req),
        .src     (dtc_src)
    );

    always_comb begin
        st_d    = st_q;
        nmi_clr = cpu_ack && (ack_src == SRC_NMI);
        edg_clr = (cpu_ack && (ack_src == SRC_EDG))
               || (dtc_ack && (dtc_src == SRC_EDG));

        // a fresh edge in the accept cycle survives the clear
        st_d.nmi_pend = nmi_edge | (st_q.nmi_pend & ~nmi_clr);
        st_d.edg_pend = edg_set  | (st_q.edg_pend & ~edg_clr);

        st_d.mask_load = cpu_ack && (ack_src != SRC_NONE);
        st_d.tr_clr    = cpu_ack && ((ack_src == SRC_LVL) || (ack_src == SRC_EDG));
        if (cpu_ack) begin
            unique case (ack_src)
                SRC_NMI: st_d.new_mask = '1;
                SRC_LVL: st_d.new_mask = cfg.lvl_pri;
                SRC_EDG: st_d.new_mask = cfg.edg_pri;
                default: st_d.new_mask = st_q.new_mask;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_load = st_q.mask_load;
    assign new_mask  = st_q.new_mask;
    assign tr_clr    = st_q.tr_clr;
endmodule

// File: rtl/eic_checker.sv
module eic_checker
    import eic_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_req,
    input logic [SRC_W-1:0] cpu_src,
    input logic [PRI_W-1:0] cpu_mask,
    input logic             cpu_ack,
    input logic [SRC_W-1:0] ack_src,
    input logic             mask_load,
    input logic [PRI_W-1:0] new_mask,
    input logic             tr_clr,
    input logic             dtc_req,
    input logic [SRC_W-1:0] dtc_src,
    input logic             nmi_pend,
    input logic [PRI_W-1:0] lvl_pri,
    input logic [PRI_W-1:0] edg_pri,
    input logic             lvl_dtc,
    input logic             edg_dtc
);
    p_quiet_in_reset_r1: assert property (@(posedge clk)
        !rst_n |-> !cpu_req && !dtc_req && !mask_load);

    p_nmi_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pend |-> cpu_req && cpu_src == SRC_NMI);

    p_lvl_above_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_src == SRC_LVL |-> lvl_pri > cpu_mask);

    p_edg_above_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_src == SRC_EDG |-> edg_pri > cpu_mask);

    p_load_follows_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack && ack_src != SRC_NONE |=> mask_load);

    p_nmi_mask_seven_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack && ack_src == SRC_NMI |=> new_mask == '1 && !tr_clr);

    p_trace_with_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tr_clr |-> mask_load);

    p_routed_not_cpu_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> !(cpu_src == SRC_LVL && lvl_dtc) && !(cpu_src == SRC_EDG && edg_dtc));

    p_dtc_valid_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dtc_req |-> dtc_src == SRC_LVL || dtc_src == SRC_EDG);
endmodule

bind ext_irq_ctrl eic_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_src   (cpu_src),
    .cpu_mask  (cpu_mask),
    .cpu_ack   (cpu_ack),
    .ack_src   (ack_src),
    .mask_load (mask_load),
    .new_mask  (new_mask),
    .tr_clr    (tr_clr),
    .dtc_req   (dtc_req),
    .dtc_src   (dtc_src),
    .nmi_pend  (st_q.nmi_pend),
    .lvl_pri   (cfg.lvl_pri),
    .edg_pri   (cfg.edg_pri),
    .lvl_dtc   (cfg.lvl_dtc),
    .edg_dtc   (cfg.edg_dtc)
);

// File: tb/ext_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_pin = 1'b0, lvl_pin_n = 1'b1, edg_pin_n = 1'b1;
    logic       wdt_ovf = 1'b0, wdt_en = 1'b0, wdt_itv_mode = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [2:0] cpu_mask = '0;
    logic       cpu_req;
    logic [1:0] cpu_src;
    logic       cpu_ack = 1'b0;
    logic [1:0] ack_src = 2'd3;
    logic       mask_load;
    logic [2:0] new_mask;
    logic       tr_clr;
    logic       dtc_req;
    logic [1:0] dtc_src;
    logic       dtc_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ext_irq_ctrl dut_i (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input int exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        nmi_pin = 1'b0; lvl_pin_n = 1'b1; edg_pin_n = 1'b1;
        wdt_ovf = 1'b0; wdt_en = 1'b0; wdt_itv_mode = 1'b0;
        cpu_mask = '0; cpu_ack = 1'b0; ack_src = 2'd3; dtc_ack = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic accept(input logic [1:0] s);
        @(negedge clk);
        cpu_ack = 1'b1; ack_src = s;
        @(negedge clk);
        cpu_ack = 1'b0; ack_src = 2'd3;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 cpu_req", cpu_req, 0);
        chk("R1 dtc_req", dtc_req, 0);
        chk("R1 mask_load", mask_load, 0);
        chk("R1 tr_clr", tr_clr, 0);
        for (int a = 0; a < 4; a++) rd_chk("R1 rdata", 2'(a), 0);
    endtask

    task automatic t_regs();
        do_reset();
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'hFF);
        rd_chk("R2 ctrl", 2'd0, 8'h07);
        rd_chk("R2 prio", 2'd1, 8'h77);
        rd_chk("R2 route", 2'd2, 8'h03);
        rd_chk("R2 unmapped", 2'd3, 8'h00);
        wr(2'd1, 8'h25);
        rd_chk("R2 prio fields", 2'd1, 8'h25);
    endtask

    task automatic t_nmi();
        do_reset();
        cpu_mask = 3'd7;
        nmi_pin = 1'b1; cyc(5);
        chk("R3 rising ignored when falling selected", cpu_req, 0);
        nmi_pin = 1'b0; cyc(5);
        chk("R3 falling latched req", cpu_req, 1);
        chk("R3 falling latched src", cpu_src, 0);
        accept(2'd0);
        chk("R9 nmi mask_load", mask_load, 1);
        chk("R9 nmi new_mask", new_mask, 7);
        chk("R9 nmi no tr_clr", tr_clr, 0);
        chk("R9 nmi cleared", cpu_req, 0);
        wr(2'd0, 8'h01);
        nmi_pin = 1'b1; cyc(5);
        chk("R3 rising latched", cpu_req, 1);
        accept(2'd0);
        nmi_pin = 1'b0; cyc(5);
        chk("R3 falling ignored when rising selected", cpu_req, 0);
    endtask

    task automatic t_level();
        do_reset();
        wr(2'd1, 8'h03);
        lvl_pin_n = 1'b0; cyc(5);
        chk("R4 disabled no req", cpu_req, 0);
        wr(2'd0, 8'h02); cyc(1);
        chk("R4 low requests", cpu_req, 1);
        chk("R4 src", cpu_src, 1);
        lvl_pin_n = 1'b1; cyc(5);
        chk("R4 dropped on high", cpu_req, 0);
    endtask

    task automatic t_wdt();
        do_reset();
        wr(2'd1, 8'h05);
        wdt_ovf = 1'b1; wdt_en = 1'b1; wdt_itv_mode = 1'b1; cyc(2);
        chk("R5 interval mode no req", cpu_req, 0);
        wdt_itv_mode = 1'b0; cyc(2);
        chk("R5 watchdog req", cpu_req, 1);
        chk("R5 watchdog src", cpu_src, 1);
        wdt_en = 1'b0; cyc(2);
        chk("R5 stopped no req", cpu_req, 0);
        wdt_ovf = 1'b0;
    endtask

    task automatic t_edge();
        do_reset();
        wr(2'd1, 8'h40);
        edg_pin_n = 1'b0; cyc(5);
        edg_pin_n = 1'b1; cyc(5);
        chk("R6 disabled edge ignored", cpu_req, 0);
        wr(2'd0, 8'h04);
        edg_pin_n = 1'b0; cyc(5);
        edg_pin_n = 1'b1; cyc(5);
        chk("R6 latched after pin high", cpu_req, 1);
        chk("R6 src", cpu_src, 2);
        accept(2'd2);
        cyc(5);
        chk("R6 rising edge ignored after clear", cpu_req, 0);
    endtask

    task automatic t_mask();
        do_reset();
        wr(2'd0, 8'h02);
        wr(2'd1, 8'h03);
        lvl_pin_n = 1'b0; cyc(4);
        cpu_mask = 3'd2; cyc(1);
        chk("R7 prio above mask", cpu_req, 1);
        cpu_mask = 3'd3; cyc(1);
        chk("R7 prio equal mask", cpu_req, 0);
        cpu_mask = 3'd4; cyc(1);
        chk("R7 prio below mask", cpu_req, 0);
        lvl_pin_n = 1'b1;
    endtask

    task automatic t_arb();
        do_reset();
        wr(2'd0, 8'h06);
        wr(2'd1, 8'h52);
        lvl_pin_n = 1'b0;
        edg_pin_n = 1'b0; cyc(5);
        chk("R8 higher edge prio wins", cpu_src, 2);
        wr(2'd1, 8'h25); cyc(1);
        chk("R8 higher level prio wins", cpu_src, 1);
        wr(2'd1, 8'h44); cyc(1);
        chk("R8 tie level wins", cpu_src, 1);
        nmi_pin = 1'b1; cyc(2);
        nmi_pin = 1'b0; cyc(5);
        chk("R8 nmi wins", cpu_src, 0);
        lvl_pin_n = 1'b1;
    endtask

    task automatic t_nested();
        do_reset();
        wr(2'd0, 8'h04);
        wr(2'd1, 8'h30);
        edg_pin_n = 1'b0; cyc(5);
        chk("R10 first req", cpu_req, 1);
        accept(2'd2);
        chk("R9 edge mask_load", mask_load, 1);
        chk("R9 edge new_mask", new_mask, 3);
        chk("R9 edge tr_clr", tr_clr, 1);
        cpu_mask = 3'd3;
        edg_pin_n = 1'b1; cyc(5);
        edg_pin_n = 1'b0; cyc(5);
        chk("R10 held off while masked", cpu_req, 0);
        cpu_mask = 3'd0; cyc(1);
        chk("R10 taken after mask drop", cpu_req, 1);
        chk("R10 src", cpu_src, 2);
    endtask

    task automatic t_route();
        do_reset();
        wr(2'd0, 8'h06);
        wr(2'd1, 8'h61);
        wr(2'd2, 8'h03);
        cpu_mask = 3'd7;
        lvl_pin_n = 1'b0;
        edg_pin_n = 1'b0; cyc(5);
        chk("R11 no cpu req", cpu_req, 0);
        chk("R11 dtc req", dtc_req, 1);
        chk("R11 dtc src by prio", dtc_src, 2);
        @(negedge clk); dtc_ack = 1'b1;
        @(negedge clk); dtc_ack = 1'b0;
        chk("R11 dtc ack clears edge", dtc_src, 1);
        wr(2'd2, 8'h01);
        cpu_mask = 3'd0;
        edg_pin_n = 1'b1; cyc(5);
        edg_pin_n = 1'b0; cyc(5);
        chk("R11 edge back to cpu", cpu_src, 2);
        chk("R11 level stays on dtc", dtc_src, 1);
        lvl_pin_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_regs();
        t_nmi();
        t_level();
        t_wdt();
        t_edge();
        t_mask();
        t_arb();
        t_nested();
        t_route();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule